// File: doc/BRIEF.md
# Receive Packet Spill Controller

This block sits on the receive side of one router port. It watches the character stream leaving the port's receive FIFO and decides, packet by packet, whether the packet goes to its output ports or is thrown away. The first character of every packet is its address. The controller presents that address to an external route lookup, takes the mask of output ports that comes back, requests those ports through a grant interface, and then passes characters across until the end marker has been forwarded. After that it releases the grants.

Software can abort the packet that is arriving. It does this by setting a spill flag, which clears itself when the work is done. The controller stops forwarding, consumes and discards the rest of the packet up to its end marker, and releases the grants. It then requests an error end marker for every output port that had already received part of the packet, so each downstream receiver sees that the packet was truncated. Packets addressed to the configuration port are discarded when configuration access is switched off. Packets with no route are also discarded. A port-disable input freezes all traffic through the port.

Top module: `spl_rx_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, grant_req, eep_req, fwd_valid and spill_flag are all 0.
- R2: Character kinds are encoded on 2 bits as 00 data, 01 normal end (EOP) and 10 error end (EEP). The first character after reset or after an end marker is the address. If it is routed, grant_req shows route_mask, and no character is forwarded until every requested port is acknowledged on grant_ack. Characters are then forwarded in order, with kind and data unchanged, up to and including the end marker. grant_req drops to 0 in the cycle after the end marker is forwarded.
- R3: A character moves across the forward interface only in a cycle where fwd_valid and fwd_ready are both 1. rx_ready is 1 in that same cycle.
- R4: When cfg_acc_en is 0, a packet whose address character equals 0 is consumed and discarded up to its end marker, and no grant is requested for it. When cfg_acc_en is 1, the same packet is forwarded like any other.
- R5: A packet whose address yields an all-zero route_mask is consumed and discarded up to its end marker.
- R6: A spill request made while a packet is in progress stops forwarding. The remaining characters of that packet, including its end marker, are consumed and never forwarded.
- R7: After a spill, each port in the packet's route mask receives exactly one EEP request, but only if at least one character was forwarded. eep_req and grant_req are never non-zero in the same cycle.
- R8: spill_flag stays 1 while a spill is in progress and returns to 0 once the end marker has been consumed and all EEP requests are acknowledged. A spill request made with no packet in progress has no effect, and the flag is back to 0 within two cycles.
- R9: Pulsing spill_clr while spill_flag is 1 clears the flag on the next edge, withdraws every pending EEP request and returns the controller to idle. The next character is taken as an address.
- R10: While port_dis is 1, rx_ready and fwd_valid are 0.
- R11: An end marker that arrives when an address is expected is consumed and discarded.
- R12: Each eep_req bit stays 1 until it is acknowledged on eep_ack, and drops in the cycle after the acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_dis | input | 1 | Freezes all transfers through the port |
| cfg_acc_en | input | 1 | Allows packets addressed to 0 |
| spill_set | input | 1 | Pulse that requests a spill |
| spill_clr | input | 1 | Pulse that aborts an active spill |
| spill_flag | output | 1 | Self-clearing spill status |
| rx_valid | input | 1 | Receive FIFO has a character |
| rx_kind | input | 2 | Character kind (00 data, 01 EOP, 10 EEP) |
| rx_data | input | DATA_W | Character value |
| rx_ready | output | 1 | Character consumed this cycle |
| route_mask | input | NPORT | Output ports for the address on rx_data |
| grant_req | output | NPORT | Ports requested for the current packet |
| grant_ack | input | NPORT | Ports granted |
| fwd_valid | output | 1 | Forwarded character valid |
| fwd_kind | output | 2 | Forwarded character kind |
| fwd_data | output | DATA_W | Forwarded character value |
| fwd_ready | input | 1 | Output side accepts the character |
| eep_req | output | NPORT | Per-port EEP injection request |
| eep_ack | input | NPORT | Per-port EEP accepted |

## Verification
The embedded properties check, on every cycle, the invariants between the interfaces. An EEP request never overlaps a grant. Forwarding happens only under a full grant. Port disable blocks the port. Grants are released after an end marker. EEP requests hold until acknowledged and drop once accepted. The spill flag reacts to an abort and clears itself when idle. Whether a packet's characters arrive in the right order, whether a dropped packet really vanishes up to its end marker, and how many EEPs each output receives after a spill or an abort can only be shown by the bench's scenarios. The bench checks these through its scoreboard and per-port counters.

// File: rtl/spl_pkg.sv
package spl_pkg;
   typedef enum logic [1:0] {
      CH_DATA = 2'b00,
      CH_EOP  = 2'b01,
      CH_EEP  = 2'b10
   } ch_kind_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_REQ   = 2'd1,
      S_FWD   = 2'd2,
      S_SPILL = 2'd3
   } spl_state_e;
endpackage

// File: rtl/spl_hdr_check.sv
module spl_hdr_check #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int NPORT  = 4,
   parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
   input  logic [DATA_W-1:0] hdr_data,
   input  logic [NPORT-1:0]  hdr_route,
   input  logic              cfg_en,
   output logic              hdr_drop
);
   logic [ADDR_W-1:0] addr;
   logic              is_cfg;

   generate
      if (ADDR_W > DATA_W) begin : g_bad_w
         $error("spl_hdr_check: ADDR_W exceeds DATA_W");
      end
      if (ADDR_W == DATA_W) begin : g_full
         assign addr = hdr_data;
      end else begin : g_low
         assign addr = hdr_data[ADDR_W-1:0];
      end
   endgenerate

   assign is_cfg   = (addr == CFG_ADDR);
   assign hdr_drop = (is_cfg && !cfg_en) || (hdr_route == '0);
endmodule

// File: rtl/spl_spill_flag.sv
module spl_spill_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic done_i,
   input  logic idle_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (flag_q) begin
         if (clr_i || done_i || idle_i) flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   // R9: an abort drops the flag on the next edge
   p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && clr_i) |=> !flag_q);
   // R8: a request with nothing in progress does not persist
   p_idle_noeffect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && idle_i) |=> !flag_q);
endmodule

// File: rtl/spl_eep_track.sv
module spl_eep_track #(
   parameter int NPORT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [NPORT-1:0] load_mask_i,
   input  logic             clear_i,
   input  logic             active_i,
   input  logic [NPORT-1:0] eep_ack,
   output logic [NPORT-1:0] eep_req,
   output logic             empty_o
);
   logic [NPORT-1:0] pend_q;

   generate
      if (NPORT < 1) begin : g_bad_n
         $error("spl_eep_track: NPORT must be at least 1");
      end
      for (genvar i = 0; i < NPORT; i++) begin : g_port
         always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
               pend_q[i] <= 1'b0;
            end else if (load_i) begin
               pend_q[i] <= load_mask_i[i];
            end else if (active_i && eep_ack[i]) begin
               pend_q[i] <= 1'b0;
            end
         end
         assign eep_req[i] = pend_q[i] && active_i;

         // R12: accepted request is withdrawn
         p_eep_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (eep_req[i] && eep_ack[i]) |=> !eep_req[i]);
         // R12: unaccepted request holds unless aborted
         p_eep_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (eep_req[i] && !eep_ack[i] && !clear_i) |=> eep_req[i]);
      end
   endgenerate

   assign empty_o = (pend_q == '0);
endmodule

// File: rtl/spl_rx_ctrl.sv
module spl_rx_ctrl
   import spl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int NPORT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_dis,
   input  logic              cfg_acc_en,
   input  logic              spill_set,
   input  logic              spill_clr,
   output logic              spill_flag,
   input  logic              rx_valid,
   input  logic [1:0]        rx_kind,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   input  logic [NPORT-1:0]  route_mask,
   output logic [NPORT-1:0]  grant_req,
   input  logic [NPORT-1:0]  grant_ack,
   output logic              fwd_valid,
   output logic [1:0]        fwd_kind,
   output logic [DATA_W-1:0] fwd_data,
   input  logic              fwd_ready,
   output logic [NPORT-1:0]  eep_req,
   input  logic [NPORT-1:0]  eep_ack
);
   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("spl_rx_ctrl: DATA_W too small");
      end
   endgenerate

   spl_state_e       st_q, st_d;
   logic [NPORT-1:0] mask_q, mask_d;
   logic             sent_q, sent_d;
   logic             end_seen_q, end_seen_d;
   logic             take, is_end, all_granted, hdr_drop;
   logic             eep_load, eep_clear, eep_active, eep_empty;
   logic [NPORT-1:0] eep_load_mask;
   logic             spill_done, in_idle, spill_go;

   assign take        = rx_valid && !port_dis;
   assign is_end      = (rx_kind != CH_DATA);
   assign all_granted = ((grant_ack & mask_q) == mask_q);
   assign spill_go    = spill_flag && !spill_clr;
   assign in_idle     = (st_q == S_IDLE);
   assign eep_active  = (st_q == S_SPILL);
   assign fwd_kind    = rx_kind;
   assign fwd_data    = rx_data;

   spl_hdr_check #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPORT(NPORT), .CFG_ADDR('0)
   ) u_hdr (
      .hdr_data(rx_data), .hdr_route(route_mask), .cfg_en(cfg_acc_en),
      .hdr_drop(hdr_drop)
   );

   spl_spill_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(spill_set), .clr_i(spill_clr),
      .done_i(spill_done), .idle_i(in_idle), .flag_o(spill_flag)
   );

   spl_eep_track #(.NPORT(NPORT)) u_eep (
      .clk(clk), .rst_n(rst_n), .load_i(eep_load), .load_mask_i(eep_load_mask),
      .clear_i(eep_clear), .active_i(eep_active), .eep_ack(eep_ack),
      .eep_req(eep_req), .empty_o(eep_empty)
   );

   always_comb begin
      st_d          = st_q;
      mask_d        = mask_q;
      sent_d        = sent_q;
      end_seen_d    = end_seen_q;
      rx_ready      = 1'b0;
      fwd_valid     = 1'b0;
      grant_req     = '0;
      eep_load      = 1'b0;
      eep_load_mask = '0;
      eep_clear     = 1'b0;
      spill_done    = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (take) begin
               if (is_end) begin
                  rx_ready = 1'b1;
               end else if (hdr_drop) begin
                  rx_ready   = 1'b1;
                  end_seen_d = 1'b0;
                  eep_load   = 1'b1;
                  st_d       = S_SPILL;
               end else begin
                  mask_d = route_mask;
                  sent_d = 1'b0;
                  st_d   = S_REQ;
               end
            end
         end
         S_REQ: begin
            grant_req = mask_q;
            if (spill_go) begin
               end_seen_d = 1'b0;
               eep_load   = 1'b1;
               st_d       = S_SPILL;
            end else if (all_granted) begin
               st_d = S_FWD;
            end
         end
         S_FWD: begin
            grant_req = mask_q;
            if (spill_go) begin
               end_seen_d    = 1'b0;
               eep_load      = 1'b1;
               eep_load_mask = sent_q ? mask_q : '0;
               st_d          = S_SPILL;
            end else begin
               fwd_valid = take;
               rx_ready  = take && fwd_ready;
               if (rx_ready) begin
                  sent_d = 1'b1;
                  if (is_end) st_d = S_IDLE;
               end
            end
         end
         S_SPILL: begin
            if (spill_flag && spill_clr) begin
               eep_clear = 1'b1;
               st_d      = S_IDLE;
            end else begin
               rx_ready = take && !end_seen_q;
               if (rx_ready && is_end) end_seen_d = 1'b1;
               if (end_seen_q && eep_empty) begin
                  spill_done = 1'b1;
                  st_d       = S_IDLE;
               end
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         mask_q     <= '0;
         sent_q     <= 1'b0;
         end_seen_q <= 1'b0;
      end else begin
         st_q       <= st_d;
         mask_q     <= mask_d;
         sent_q     <= sent_d;
         end_seen_q <= end_seen_d;
      end
   end

   // R7: error markers only after the grant is gone
   p_eep_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eep_req != '0) |-> (grant_req == '0));
   // R2: forwarding only under a complete grant
   p_fwd_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> ((grant_req != '0) && ((grant_ack & grant_req) == grant_req)));
   // R2: grant released after a forwarded end marker
   p_end_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_ready && (fwd_kind != CH_DATA)) |=> (grant_req == '0));
   // R10: disabled port moves nothing
   p_dis_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      port_dis |-> (!rx_ready && !fwd_valid));
   // R3: a forward handshake consumes the receive character
   p_fwd_consume_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_ready) |-> rx_ready);
   // R4: configuration address refused when access is off
   p_cfg_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_idle && take && !is_end && (rx_data == '0) && !cfg_acc_en) |=> (grant_req == '0));
endmodule

// File: tb/spl_rx_ctrl_tb_top.sv
module spl_rx_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int NP = 4;

   typedef struct packed {
      logic [1:0]    k;
      logic [DW-1:0] d;
   } ch_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic port_dis = 1'b0, cfg_acc_en = 1'b0, spill_set = 1'b0, spill_clr = 1'b0;
   logic spill_flag;
   logic rx_valid = 1'b0;
   logic [1:0] rx_kind = 2'b00;
   logic [DW-1:0] rx_data = '0;
   logic rx_ready;
   logic [NP-1:0] route_mask, grant_req, eep_req, eep_ack;
   logic [NP-1:0] grant_ack = '0;
   logic fwd_valid, fwd_ready = 1'b1;
   logic [1:0] fwd_kind;
   logic [DW-1:0] fwd_data;

   ch_t src_q[$];
   ch_t exp_q[$];
   int checks = 0, fails = 0, cyc = 0;
   int eep_cnt[NP];
   logic [NP-1:0] gnt_seen = '0;
   logic ack_en = 1'b1;
   logic rdy_alt = 1'b0;
   logic pop_now = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [NP-1:0] route_of(input logic [DW-1:0] a);
      if (a == 8'hFF) return '0;
      if (a == 8'hF0) return 4'b0110;
      return NP'(1) << a[1:0];
   endfunction

   assign route_mask = route_of(rx_data);
   assign eep_ack = eep_req & {NP{ack_en}};

   always @(posedge clk) grant_ack <= rst_n ? grant_req : '0;

   spl_rx_ctrl #(.DATA_W(DW), .ADDR_W(DW), .NPORT(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .port_dis(port_dis), .cfg_acc_en(cfg_acc_en),
      .spill_set(spill_set), .spill_clr(spill_clr), .spill_flag(spill_flag),
      .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_data(rx_data), .rx_ready(rx_ready),
      .route_mask(route_mask), .grant_req(grant_req), .grant_ack(grant_ack),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_data(fwd_data),
      .fwd_ready(fwd_ready), .eep_req(eep_req), .eep_ack(eep_ack)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic refresh();
      rx_valid = (src_q.size() > 0);
      if (rx_valid) {rx_kind, rx_data} = src_q[0];
      else {rx_kind, rx_data} = '0;
   endtask

   // monitor: scoreboard pop and per-port counters
   always @(negedge clk) begin
      pop_now = rx_valid && rx_ready;
      gnt_seen = gnt_seen | grant_req;
      if (fwd_valid && fwd_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected forward", int'({fwd_kind, fwd_data}), 0);
         end else begin
            ch_t e;
            e = exp_q.pop_front();
            check({fwd_kind, fwd_data} == e, "R2 forwarded character",
                  int'({fwd_kind, fwd_data}), int'(e));
         end
      end
      for (int p = 0; p < NP; p++)
         if (eep_req[p] && eep_ack[p]) eep_cnt[p]++;
   end

   always @(posedge clk) begin
      #1;
      cyc++;
      if (pop_now) void'(src_q.pop_front());
      refresh();
      fwd_ready = rdy_alt ? cyc[0] : 1'b1;
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic push_pkt(input logic [DW-1:0] hdr, input int n, input bit with_end,
                           input bit expect_fwd);
      ch_t c;
      for (int i = 0; i <= n + 1; i++) begin
         if (i == n + 1 && !with_end) break;
         if (i == 0) c = {2'b00, hdr};
         else if (i <= n) c = {2'b00, DW'(hdr + i)};
         else c = {2'b01, DW'(8'hE0 + n)};
         src_q.push_back(c);
         if (expect_fwd) exp_q.push_back(c);
      end
      refresh();
   endtask

   task automatic drain();
      int t = 0;
      while ((src_q.size() > 0 || exp_q.size() > 0) && t < 2000) begin
         tick(1);
         t++;
      end
      tick(4);
      check(t < 2000, "R2 drain timeout", src_q.size() + exp_q.size(), 0);
   endtask

   task automatic pulse_set();
      spill_set = 1'b1;
      tick(1);
      spill_set = 1'b0;
   endtask

   task automatic clr_cnt();
      for (int p = 0; p < NP; p++) eep_cnt[p] = 0;
      gnt_seen = '0;
   endtask

   function automatic int eep_total();
      int s = 0;
      for (int p = 0; p < NP; p++) s += eep_cnt[p];
      return s;
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      clr_cnt();
      tick(3);
      @(negedge clk);
      check(grant_req == '0 && eep_req == '0, "R1 reset outputs", int'({grant_req, eep_req}), 0);
      check(!fwd_valid && !spill_flag, "R1 reset fwd/flag", int'({fwd_valid, spill_flag}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(grant_req == '0 && !fwd_valid && !spill_flag, "R1 first cycle", int'(grant_req), 0);
      tick(1);

      // R2 R3 unicast with a stalling output
      rdy_alt = 1'b1;
      push_pkt(8'h02, 4, 1'b1, 1'b1);
      drain();
      rdy_alt = 1'b0;
      check(eep_total() == 0, "R7 no spurious EEP", eep_total(), 0);

      // R2 multicast
      push_pkt(8'hF0, 2, 1'b1, 1'b1);
      drain();

      // R4 configuration address refused, then accepted
      clr_cnt();
      push_pkt(8'h00, 3, 1'b1, 1'b0);
      push_pkt(8'h01, 1, 1'b1, 1'b1);
      drain();
      check(gnt_seen[0] == 1'b0, "R4 no grant for refused packet", int'(gnt_seen), 2);
      check(eep_total() == 0, "R4 no EEP on refused packet", eep_total(), 0);
      cfg_acc_en = 1'b1;
      push_pkt(8'h00, 2, 1'b1, 1'b1);
      drain();
      cfg_acc_en = 1'b0;

      // R5 unrouted, R11 stray end marker
      push_pkt(8'hFF, 2, 1'b1, 1'b0);
      src_q.push_back({2'b10, 8'h55});
      push_pkt(8'h03, 2, 1'b1, 1'b1);
      drain();

      // R6 R7 R8 spill mid-packet on a multicast
      clr_cnt();
      push_pkt(8'hF0, 3, 1'b0, 1'b1);
      drain();
      pulse_set();
      tick(3);
      check(spill_flag == 1'b1, "R8 flag held during spill", spill_flag, 1);
      push_pkt(8'h07, 2, 1'b1, 1'b0);
      drain();
      check(eep_cnt[1] == 1 && eep_cnt[2] == 1, "R7 EEP per routed port",
            eep_cnt[1] * 16 + eep_cnt[2], 17);
      check(eep_cnt[0] == 0 && eep_cnt[3] == 0, "R7 no EEP elsewhere",
            eep_cnt[0] + eep_cnt[3], 0);
      check(spill_flag == 1'b0, "R8 flag self-clears", spill_flag, 0);
      push_pkt(8'h01, 1, 1'b1, 1'b1);
      drain();

      // R8 spill with no packet
      clr_cnt();
      pulse_set();
      tick(2);
      check(spill_flag == 1'b0, "R8 idle spill no effect", spill_flag, 0);
      push_pkt(8'h02, 1, 1'b1, 1'b1);
      drain();
      check(eep_total() == 0, "R8 idle spill no EEP", eep_total(), 0);

      // R9 R12 abort while EEP pending
      clr_cnt();
      ack_en = 1'b0;
      push_pkt(8'h02, 2, 1'b0, 1'b1);
      drain();
      pulse_set();
      tick(4);
      @(negedge clk);
      check(eep_req == 4'b0100, "R12 EEP held until ack", int'(eep_req), 4);
      tick(0);
      spill_clr = 1'b1;
      tick(1);
      spill_clr = 1'b0;
      tick(1);
      @(negedge clk);
      check(!spill_flag && eep_req == '0, "R9 abort clears flag and EEP",
            int'({spill_flag, eep_req}), 0);
      ack_en = 1'b1;
      tick(1);
      push_pkt(8'h03, 1, 1'b1, 1'b1);
      drain();
      check(eep_total() == 0, "R9 aborted EEP never sent", eep_total(), 0);

      // R10 port disable
      port_dis = 1'b1;
      push_pkt(8'h01, 3, 1'b1, 1'b1);
      tick(5);
      @(negedge clk);
      check(!rx_ready && !fwd_valid, "R10 disabled port idle", int'({rx_ready, fwd_valid}), 0);
      check(src_q.size() == 5, "R10 nothing consumed", src_q.size(), 5);
      tick(0);
      port_dis = 1'b0;
      drain();

      check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule